// File: doc/BRIEF.md
# Dictionary Word Compressor Encoder

The encoder takes one 32-bit word per cycle and turns it into one variable-length codeword. An external dictionary compares the word with its entries in the same cycle. For each entry it returns a 4-bit byte-equality mask, ordered by logical recency. The encoder picks the best entry and sizes the index field from its own count of filled entries. It appends a prefix-coded match type and then the bytes that did not match. It also issues the matching dictionary update: either promote the hit entry or insert the new word at the front.

Zero words are not encoded one by one. A run of zero words is held open and later emitted as a single codeword that names the reserved index 0 and carries the run length. The run is closed by the next non-zero word, by reaching 256 words, or by the flush input. Packing codewords into a fixed-width stream is left to a downstream block, which receives a left-aligned 64-bit vector and a bit count.

Top module: `dict_word_encoder`

## Requirements
- R1: `ready_o` is high in every cycle except the cycle in which an open zero run is closed by flush or by a valid non-zero word. In that cycle the word is not consumed. A word is consumed when `valid_i` and `ready_o` are both high.
- R2: A miss produces the codeword bit 0 followed by the 32-bit word, with a length of 33. It also issues an insert update carrying the word.
- R3: The index field is ceil(log2(fill+1)) bits wide, where fill counts the entries inserted so far and saturates at DEPTH. The entry at logical position p is given index p+1. Index 0 is reserved for zero runs.
- R4: A match codeword is bit 1, then the index, then the type code, then each unmatched byte as an 8-bit literal, taken from byte 3 down to byte 0.
- R5: Mask bit i set means byte i (bits 8i+7..8i) matches. The type codes are as follows. Full match is 00. For three matching bytes, the code depends on the missing byte: byte 0 gives 010, byte 1 gives 011, byte 2 gives 100, byte 3 gives 101. For two matching bytes, the code depends on the matching pair: {1,0} gives 11000, {2,0} gives 11001, {2,1} gives 11010, {3,0} gives 11011, {3,1} gives 11100, {3,2} gives 11101.
- R6: The entry with the most matching bytes wins. A tie goes to the lowest logical position. Entries with fewer than two matching bytes, and positions at or beyond fill, never match.
- R7: A full match issues a promote update for the hit position and leaves fill unchanged. A partial match or a miss issues an insert update.
- R8: An accepted zero word produces no codeword and no update. A run codeword is bit 1, then index 0 in the current index width, then 8 bits holding the run count minus one.
- R9: A valid non-zero word that arrives during an open run causes the run codeword to be emitted in that cycle, and the word is encoded in the next cycle. The 256th consecutive zero word emits the run codeword, with count field 255, in the cycle it is accepted.
- R10: `flush_i` closes an open run by emitting its codeword, as in R1. When no run is open, flush has no effect.
- R11: The codeword is left-aligned in `cw_o`, and all bits past `cw_len_o` are zero.
- R12: After reset, fill is 0, no run is open, `ready_o` is high, and no codeword or update is issued until input arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word valid |
| ready_o | output | 1 | Input word accepted when high together with valid_i |
| word_i | input | 32 | Input word |
| flush_i | input | 1 | Close any open zero run |
| match_mask_i | input | DEPTH*4 | Byte-equality masks, entry p at bits 4p+3..4p, p=0 most recent |
| cw_valid_o | output | 1 | Codeword valid this cycle |
| cw_o | output | 64 | Codeword, left-aligned |
| cw_len_o | output | 7 | Codeword length in bits |
| upd_valid_o | output | 1 | Dictionary update command valid |
| upd_promote_o | output | 1 | 1: move entry upd_pos_o to front, 0: insert upd_word_o at front |
| upd_pos_o | output | POS_W | Logical position of the hit entry |
| upd_word_o | output | 32 | Word to insert |

## Verification
A wrong fill count shows up as an index field that is too wide or too narrow. This changes the codeword length and shifts every later field, and it is visible on the first match or run codeword after the error. A run counter that is off by one, or a run flag that is stuck, shows in the count field or in a missing or stalled codeword when the run closes. A selection fault appears at once as a wrong index or type code on the word that triggers it. The same fault also appears as a wrong promote or insert command in that same cycle.

// File: rtl/dwe_pkg.sv
package dwe_pkg;
  typedef enum logic [1:0] {CW_NONE, CW_MISS, CW_MATCH, CW_RUN} cw_kind_e;

  typedef struct packed {
    logic [4:0] code;
    logic [2:0] len;
  } tcode_t;

  function automatic tcode_t type_code(logic [3:0] m);
    tcode_t t;
    unique case (m)
      4'b1111: t = '{5'b00000, 3'd2};
      4'b1110: t = '{5'b00010, 3'd3};
      4'b1101: t = '{5'b00011, 3'd3};
      4'b1011: t = '{5'b00100, 3'd3};
      4'b0111: t = '{5'b00101, 3'd3};
      4'b0011: t = '{5'b11000, 3'd5};
      4'b0101: t = '{5'b11001, 3'd5};
      4'b0110: t = '{5'b11010, 3'd5};
      4'b1001: t = '{5'b11011, 3'd5};
      4'b1010: t = '{5'b11100, 3'd5};
      4'b1100: t = '{5'b11101, 3'd5};
      default: t = '{5'b00000, 3'd0};
    endcase
    return t;
  endfunction

  // place val (low w bits) at bit offset pos from the MSB
  function automatic logic [63:0] cw_put(logic [63:0] acc, logic [6:0] pos,
                                         logic [31:0] val, logic [6:0] w);
    logic [63:0] v;
    v = 64'(val) & ((64'd1 << w) - 64'd1);
    return acc | (v << (7'd64 - pos - w));
  endfunction
endpackage

// File: rtl/dwe_match_sel.sv
module dwe_match_sel #(
  parameter int DEPTH  = 15,
  parameter int POS_W  = $clog2(DEPTH),
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH*4-1:0] masks_i,
  input  logic [FILL_W-1:0]  fill_i,
  output logic               hit_o,
  output logic [POS_W-1:0]   pos_o,
  output logic [3:0]         mask_o
);
  logic [2:0] score [DEPTH];

  for (genvar p = 0; p < DEPTH; p++) begin : g_score
    logic [3:0] m;
    logic [2:0] ones;
    assign m    = masks_i[p*4 +: 4];
    assign ones = 3'($countones(m));
    assign score[p] = (32'(p) < 32'(fill_i) && ones >= 3'd2) ? ones : 3'd0;
  end

  logic [2:0] best;
  always_comb begin
    best  = '0;
    pos_o = '0;
    // strict compare keeps the lowest position on ties
    for (int p = 0; p < DEPTH; p++) begin
      if (score[p] > best) begin
        best  = score[p];
        pos_o = POS_W'(p);
      end
    end
  end

  assign hit_o  = best != 3'd0;
  assign mask_o = masks_i[pos_o*4 +: 4];
endmodule

// File: rtl/dwe_cw_build.sv
module dwe_cw_build
  import dwe_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  cw_kind_e         kind_i,
  input  logic [31:0]      word_i,
  input  logic [3:0]       mask_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [6:0]       idx_w_i,
  input  logic [7:0]       run_len_i,
  output logic [63:0]      cw_o,
  output logic [6:0]       cw_len_o
);
  tcode_t tc;
  assign tc = type_code(mask_i);

  always_comb begin
    cw_o     = '0;
    cw_len_o = '0;
    unique case (kind_i)
      CW_MISS: begin
        cw_o     = cw_put(cw_o, 7'd0, 32'd0, 7'd1);
        cw_o     = cw_put(cw_o, 7'd1, word_i, 7'd32);
        cw_len_o = 7'd33;
      end
      CW_MATCH: begin
        cw_o     = cw_put(cw_o, 7'd0, 32'd1, 7'd1);
        cw_o     = cw_put(cw_o, 7'd1, 32'(idx_i), idx_w_i);
        cw_len_o = 7'd1 + idx_w_i;
        cw_o     = cw_put(cw_o, cw_len_o, 32'(tc.code), 7'(tc.len));
        cw_len_o = cw_len_o + 7'(tc.len);
        for (int b = 3; b >= 0; b--) begin
          if (!mask_i[b]) begin
            cw_o     = cw_put(cw_o, cw_len_o, 32'(word_i[b*8 +: 8]), 7'd8);
            cw_len_o = cw_len_o + 7'd8;
          end
        end
      end
      CW_RUN: begin
        cw_o     = cw_put(cw_o, 7'd0, 32'd1, 7'd1);
        cw_len_o = 7'd1 + idx_w_i; // index 0 is all zeros
        cw_o     = cw_put(cw_o, cw_len_o, 32'(run_len_i), 7'd8);
        cw_len_o = cw_len_o + 7'd8;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dict_word_encoder.sv
module dict_word_encoder
  import dwe_pkg::*;
#(
  parameter int DEPTH = 15,
  parameter int POS_W = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  output logic               ready_o,
  input  logic [31:0]        word_i,
  input  logic               flush_i,
  input  logic [DEPTH*4-1:0] match_mask_i,
  output logic               cw_valid_o,
  output logic [63:0]        cw_o,
  output logic [6:0]         cw_len_o,
  output logic               upd_valid_o,
  output logic               upd_promote_o,
  output logic [POS_W-1:0]   upd_pos_o,
  output logic [31:0]        upd_word_o
);
  localparam int FILL_W = $clog2(DEPTH + 1);
  localparam int IDX_W  = FILL_W;
  localparam logic [7:0] RUN_LAST = 8'd254; // count-1 before the 256th zero

  logic [FILL_W-1:0] fill_q;
  logic              run_open_q;
  logic [7:0]        run_cnt_q;

  logic is_zero, close_run, accept, run_full, emit_run, emit_word;
  logic hit, full_hit;
  logic [POS_W-1:0] pos;
  logic [3:0] mask;
  logic [6:0] idx_w;
  logic [IDX_W-1:0] idx;
  logic [7:0] run_len;
  cw_kind_e kind;

  assign is_zero   = word_i == 32'd0;
  assign close_run = run_open_q && (flush_i || (valid_i && !is_zero));
  assign accept    = valid_i && !close_run;
  assign run_full  = accept && is_zero && run_open_q && run_cnt_q == RUN_LAST;
  assign emit_run  = close_run || run_full;
  assign emit_word = accept && !is_zero;
  assign ready_o   = !close_run;

  dwe_match_sel #(.DEPTH(DEPTH), .POS_W(POS_W), .FILL_W(FILL_W)) i_sel (
    .masks_i (match_mask_i),
    .fill_i  (fill_q),
    .hit_o   (hit),
    .pos_o   (pos),
    .mask_o  (mask)
  );

  assign full_hit = hit && mask == 4'hf;
  assign idx_w    = 7'($clog2(32'(fill_q) + 1));
  assign idx      = emit_run ? '0 : IDX_W'(pos) + IDX_W'(1);
  assign run_len  = run_full ? 8'd255 : run_cnt_q;

  always_comb begin
    if (emit_run)       kind = CW_RUN;
    else if (emit_word) kind = hit ? CW_MATCH : CW_MISS;
    else                kind = CW_NONE;
  end

  dwe_cw_build #(.IDX_W(IDX_W)) i_build (
    .kind_i    (kind),
    .word_i    (word_i),
    .mask_i    (mask),
    .idx_i     (idx),
    .idx_w_i   (idx_w),
    .run_len_i (run_len),
    .cw_o      (cw_o),
    .cw_len_o  (cw_len_o)
  );

  assign cw_valid_o    = emit_run || emit_word;
  assign upd_valid_o   = emit_word;
  assign upd_promote_o = emit_word && full_hit;
  assign upd_pos_o     = pos;
  assign upd_word_o    = word_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q     <= '0;
      run_open_q <= 1'b0;
      run_cnt_q  <= '0;
    end else begin
      if (emit_word && !full_hit && 32'(fill_q) < DEPTH) fill_q <= fill_q + 1'b1;
      if (close_run || run_full) begin
        run_open_q <= 1'b0;
      end else if (accept && is_zero) begin
        if (!run_open_q) begin
          run_open_q <= 1'b1;
          run_cnt_q  <= '0;
        end else begin
          run_cnt_q <= run_cnt_q + 8'd1;
        end
      end
    end
  end

  // R3
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(fill_q) <= DEPTH);
  // R1
  stall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> run_open_q);
  // R8
  zero_no_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && is_zero) |-> !upd_valid_o);
  // R11
  cw_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_valid_o |-> (cw_o << cw_len_o) == 64'd0);
  // R7
  promote_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_o && upd_promote_o) |-> match_mask_i[upd_pos_o*4 +: 4] == 4'hf);
  // R9
  run_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_open_q |-> run_cnt_q != 8'd255);
endmodule

// File: tb/test_dict_word_encoder.sv
module test_dict_word_encoder;
  localparam int DEPTH = 15;
  localparam int POS_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, flush = 1'b0;
  logic [31:0] word = '0;
  logic [DEPTH*4-1:0] masks = '0;
  logic ready, cw_valid, upd_valid, upd_promote;
  logic [63:0] cw;
  logic [6:0] cw_len;
  logic [POS_W-1:0] upd_pos;
  logic [31:0] upd_word;

  int checks = 0, failures = 0, fill = 0;
  logic [63:0] e_cw;
  int e_len;

  always #5 clk = ~clk;

  dict_word_encoder #(.DEPTH(DEPTH)) i_dict_word_encoder (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .ready_o(ready),
    .word_i(word), .flush_i(flush), .match_mask_i(masks),
    .cw_valid_o(cw_valid), .cw_o(cw), .cw_len_o(cw_len),
    .upd_valid_o(upd_valid), .upd_promote_o(upd_promote),
    .upd_pos_o(upd_pos), .upd_word_o(upd_word)
  );

  function automatic logic [DEPTH*4-1:0] ent(int p, logic [3:0] m);
    logic [DEPTH*4-1:0] v = '0;
    v[p*4 +: 4] = m;
    return v;
  endfunction

  function automatic int iw(int f);
    return $clog2(f + 1);
  endfunction

  task automatic eb_clear(); e_cw = '0; e_len = 0; endtask
  task automatic eb_put(logic [31:0] val, int w);
    for (int i = w - 1; i >= 0; i--) begin
      e_cw[63 - e_len] = val[i];
      e_len++;
    end
  endtask

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_cw(string req);
    chk(req, "cw_valid", 64'(cw_valid), 64'd1);
    chk(req, "cw", cw, e_cw);
    chk(req, "cw_len", 64'(cw_len), 64'(e_len));
  endtask

  task automatic step(logic v, logic [31:0] w, logic f, logic [DEPTH*4-1:0] m);
    @(negedge clk);
    valid = v; word = w; flush = f; masks = m;
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R12", "ready", 64'(ready), 64'd1);
    chk("R12", "cw_valid", 64'(cw_valid), 64'd0);
    chk("R12", "upd_valid", 64'(upd_valid), 64'd0);
  endtask

  task automatic do_miss(logic [31:0] w, string req);
    step(1, w, 0, '0);
    eb_clear(); eb_put(0, 1); eb_put(w, 32);
    chk_cw(req);
    chk(req, "upd_valid", 64'(upd_valid), 64'd1);
    chk(req, "upd_promote", 64'(upd_promote), 64'd0);
    chk(req, "upd_word", 64'(upd_word), 64'(w));
    if (fill < DEPTH) fill++;
  endtask

  task automatic t_full_hit();
    step(1, 32'h5566_7788, 0, ent(0, 4'hf));
    eb_clear(); eb_put(1, 1); eb_put(1, iw(fill)); eb_put(2'b00, 2);
    chk_cw("R4");
    chk("R7", "promote", 64'(upd_promote), 64'd1);
    chk("R7", "pos", 64'(upd_pos), 64'd0);
  endtask

  task automatic t_partial3();
    step(1, 32'h1122_3344, 0, ent(1, 4'b1110));
    eb_clear(); eb_put(1, 1); eb_put(2, iw(fill)); eb_put(3'b010, 3); eb_put(8'h44, 8);
    chk_cw("R5");
    chk("R7", "insert", 64'(upd_promote), 64'd0);
    fill++;
  endtask

  task automatic t_priority();
    step(1, 32'hDEAD_BEEF, 0, ent(0, 4'b0011) | ent(1, 4'b0001) | ent(2, 4'b0111)
                             | ent(fill, 4'hf));
    eb_clear(); eb_put(1, 1); eb_put(3, iw(fill)); eb_put(3'b101, 3); eb_put(8'hDE, 8);
    chk_cw("R6");
    fill++;
  endtask

  task automatic t_tie();
    step(1, 32'h0BAD_F00D, 0, ent(1, 4'hf) | ent(3, 4'hf));
    eb_clear(); eb_put(1, 1); eb_put(2, iw(fill)); eb_put(2'b00, 2);
    chk_cw("R6");
    chk("R6", "tie pos", 64'(upd_pos), 64'd1);
  endtask

  task automatic t_two_byte();
    step(1, 32'h0102_0304, 0, ent(0, 4'b1010));
    eb_clear(); eb_put(1, 1); eb_put(1, iw(fill)); eb_put(5'b11100, 5);
    eb_put(8'h02, 8); eb_put(8'h04, 8);
    chk_cw("R5");
    fill++;
  endtask

  task automatic t_one_byte();
    step(1, 32'hCAFE_0001, 0, ent(0, 4'b0001));
    eb_clear(); eb_put(0, 1); eb_put(32'hCAFE_0001, 32);
    chk_cw("R6");
    fill++;
  endtask

  task automatic t_zero_run();
    for (int i = 0; i < 3; i++) begin
      step(1, 0, 0, '0);
      chk("R8", "ready", 64'(ready), 64'd1);
      chk("R8", "cw_valid", 64'(cw_valid), 64'd0);
      chk("R8", "upd_valid", 64'(upd_valid), 64'd0);
    end
    step(1, 32'h7777_0000, 0, '0);
    chk("R9", "stall", 64'(ready), 64'd0);
    chk("R9", "no upd", 64'(upd_valid), 64'd0);
    eb_clear(); eb_put(1, 1); eb_put(0, iw(fill)); eb_put(2, 8);
    chk_cw("R8");
    step(1, 32'h7777_0000, 0, '0);
    chk("R9", "ready", 64'(ready), 64'd1);
    eb_clear(); eb_put(0, 1); eb_put(32'h7777_0000, 32);
    chk_cw("R2");
    fill++;
  endtask

  task automatic t_run_cap();
    for (int i = 0; i < 255; i++) begin
      step(1, 0, 0, '0);
      if (cw_valid) chk("R9", "early cw", 64'(cw_valid), 64'd0);
    end
    step(1, 0, 0, '0);
    chk("R9", "ready", 64'(ready), 64'd1);
    eb_clear(); eb_put(1, 1); eb_put(0, iw(fill)); eb_put(255, 8);
    chk_cw("R9");
    step(0, 0, 1, '0);
    chk("R10", "idle flush", 64'(cw_valid), 64'd0);
    chk("R10", "idle ready", 64'(ready), 64'd1);
    step(1, 0, 0, '0);
    chk("R8", "open", 64'(cw_valid), 64'd0);
    step(0, 0, 1, '0);
    chk("R10", "ready", 64'(ready), 64'd0);
    eb_clear(); eb_put(1, 1); eb_put(0, iw(fill)); eb_put(0, 8);
    chk_cw("R10");
    step(0, 0, 0, '0);
    chk("R10", "closed", 64'(cw_valid), 64'd0);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 10; i++) do_miss(32'h9000_0000 + 32'(i), "R2");
    chk("R3", "fill model", 64'(fill), 64'(DEPTH));
    for (int k = 0; k < 2; k++) begin
      step(1, 32'h4242_4242, 0, ent(DEPTH - 1, 4'hf));
      eb_clear(); eb_put(1, 1); eb_put(DEPTH, iw(DEPTH)); eb_put(2'b00, 2);
      chk_cw("R3");
      do_miss(32'h8000_0000 + 32'(k), "R3");
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    do_miss(32'hA1B2_C3D4, "R2");
    t_full_hit();
    do_miss(32'h0000_00F1, "R2");
    do_miss(32'h0000_00F2, "R2");
    t_partial3();
    t_priority();
    t_tie();
    t_two_byte();
    t_one_byte();
    t_zero_run();
    t_run_cap();
    t_saturate();
    step(0, 0, 0, '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule